// File: doc/BRIEF.md
# Wave-to-Pipeline Funnel Adapter

This block connects a lane-parallel vector datapath to deep streaming pipelines that are narrower than the datapath. The datapath presents one wave per cycle, and each lane carries two operand words, A and B. The shared pipeline needs three vector operands and produces two results for each element. Because of this, one element's operand set arrives over two accepted beats. The phase-0 beat carries the first pair, and the phase-1 beat carries the third operand. The results leave as two consecutive output waves. The adapter holds one beat's worth of phase-0 operands. When the set is complete it latches the whole wave. It then feeds the lanes of each lane pair into their pipeline one after the other during the two-cycle input period. A tag that travels with each element through a fixed-latency placeholder pipeline lets the adapter place every result back onto the lane it came from.

Two scalar operands are also part of the computation. They are not selected by an opcode bit. Instead, each instruction start flips the block between a scalar-load instruction and a vector-execute instruction. Loaded scalars stay in internal registers and apply to every element until the next load.

Top module: `wave_funnel`

## Requirements
- R1: While reset is asserted and after it is released with no input, out_valid is 0 and out_be is all zero.
- R2: In execute mode, the beat accepted with in_start (or the first accepted beat after a completed set) is phase 0, supplying A1 from in_a and B1 from in_b. The next accepted beat is phase 1, supplying A2 from in_a, and its in_b is ignored. Cycles with in_valid low do not advance the phase.
- R3: For each enabled lane, the D1 result is A1+B1+K0 and the D2 result is A2-K1, both modulo 2^W. K0 and K1 are the scalar registers.
- R4: The D1 wave appears on the outputs LAT+2 rising edges after the edge that accepts the phase-1 beat. The D2 wave follows on the next edge. No wave is presented at any other time.
- R5: Lane l is served by pipeline l/2 in slot l%2. Its results return on lane l, in out_d bits [l*W +: W].
- R6: A lane's result is real only when in_en for that lane is 1 on both beats of the set. Such a lane gets out_be bits [l*W/8 +: W/8] all ones. Any other lane gets zero byte enables and zero data.
- R7: The first in_start after reset begins a scalar-load instruction, and each later in_start toggles between load and execute. Every accepted beat of a load instruction sets K0 from lane 0 of in_a and K1 from lane 0 of in_b, and it produces no output wave.
- R8: The scalars are captured when a set completes. A reload after that point does not change results already in flight.
- R9: Sets that complete every two cycles back to back produce a continuous stream of output waves with no loss.
- R10: out_sel is 0 on the D1 wave and 1 on the D2 wave that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_start | input | 1 | Begins a new instruction and toggles the load/execute mode |
| in_valid | input | 1 | Input wave is present this cycle |
| in_en | input | LANES | Per-lane data enable |
| in_a | input | LANES*W | Operand port A, lane l at [l*W +: W] |
| in_b | input | LANES*W | Operand port B, lane l at [l*W +: W] |
| out_valid | output | 1 | Output wave is present |
| out_sel | output | 1 | 0 for a D1 wave, 1 for a D2 wave |
| out_be | output | LANES*W/8 | Byte enables of the output wave |
| out_d | output | LANES*W | Result data, lane l at [l*W +: W] |

## Verification
The bench stretches the gap between the two beats of a set with idle cycles. A design that advanced its phase on invalid cycles would combine operands from the wrong beats. It loads new scalars while earlier results are still inside the pipeline, which catches a design that reads the scalars at issue or exit instead of at set completion. Sets with uneven lane enables across the two beats show whether byte enables and data are masked per lane. Back-to-back sets, and starts issued partway through a set, reveal any slip in lane realignment, since a slot tag that is off by one would swap results between the two lanes of a pair.

// File: rtl/funnel_pkg.sv
package funnel_pkg;
  // vector operands consumed and results produced per element
  localparam int NUM_SRC = 3;
  localparam int NUM_RES = 2;
  // cycles between complete operand sets: max(ceil(src/2), res)
  localparam int PERIOD = (((NUM_SRC + 1) / 2) > NUM_RES) ? ((NUM_SRC + 1) / 2) : NUM_RES;

  typedef enum logic {
    MODE_LOAD = 1'b0,
    MODE_EXEC = 1'b1
  } instr_mode_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/funnel_seq.sv
module funnel_seq
  import funnel_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 32,
  parameter int P     = 2,
  parameter int PW    = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               valid,
  input  logic [LANES-1:0]   en,
  input  logic [LANES*W-1:0] a,
  input  logic [LANES*W-1:0] b,
  output logic [LANES*W-1:0] set_a1,
  output logic [LANES*W-1:0] set_b1,
  output logic [LANES*W-1:0] set_a2,
  output logic [LANES-1:0]   set_en,
  output logic [W-1:0]       set_k0,
  output logic [W-1:0]       set_k1,
  output logic               iss_vld,
  output logic [PW-1:0]      iss_idx
);
  localparam logic [PW-1:0] LAST_PH = PW'(P - 1);

  instr_mode_e          mode_q, mode_now;
  logic [PW-1:0]        ph_q, ph_now;
  logic [LANES*W-1:0]   hold_a, hold_b;
  logic [LANES-1:0]     hold_en;
  logic [W-1:0]         k0_q, k1_q;
  logic                 exec_beat, load_beat, last_ph, complete;

  always_comb begin
    mode_now  = start ? ((mode_q == MODE_EXEC) ? MODE_LOAD : MODE_EXEC) : mode_q;
    ph_now    = start ? '0 : ph_q;
    exec_beat = valid && (mode_now == MODE_EXEC);
    load_beat = valid && (mode_now == MODE_LOAD);
    last_ph   = (ph_now == LAST_PH);
    complete  = exec_beat && last_ph;
  end

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_EXEC;
      ph_q    <= '0;
      k0_q    <= '0;
      k1_q    <= '0;
      iss_vld <= 1'b0;
      iss_idx <= '0;
    end else begin
      mode_q <= mode_now;
      if (exec_beat) ph_q <= last_ph ? '0 : PW'(ph_now + 1'b1);
      else           ph_q <= ph_now;
      if (load_beat) begin
        k0_q <= a[W-1:0];
        k1_q <= b[W-1:0];
      end
      if (complete) begin
        iss_vld <= 1'b1;
        iss_idx <= '0;
      end else if (iss_vld) begin
        if (iss_idx == LAST_PH) begin
          iss_vld <= 1'b0;
          iss_idx <= '0;
        end else begin
          iss_idx <= PW'(iss_idx + 1'b1);
        end
      end
    end
  end

  // one beat of operand holding plus the latched complete wave
  always_ff @(posedge clk) begin
    if (exec_beat && (ph_now == '0)) begin
      hold_a  <= a;
      hold_b  <= b;
      hold_en <= en;
    end
    if (complete) begin
      set_a1 <= hold_a;
      set_b1 <= hold_b;
      set_a2 <= a;
      set_en <= hold_en & en;
      set_k0 <= k0_q;
      set_k1 <= k1_q;
    end
  end

  // R2: a start beat in execute mode leaves the block expecting phase 1
  a_r2_phase_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && valid && (mode_q == MODE_LOAD)) |=> (ph_q == PW'(1)));

  // R7: scalars change only on accepted beats
  a_r7_scalar_hold: assert property (@(posedge clk) disable iff (rst)
    (!valid) |=> ($stable(k0_q) && $stable(k1_q)));

  // R9: issue index stays inside the input period
  a_r9_issue_window: assert property (@(posedge clk) disable iff (rst)
    iss_vld |-> (int'(iss_idx) < P));
endmodule

// File: rtl/funnel_pipe.sv
module funnel_pipe #(
  parameter int W   = 32,
  parameter int P   = 2,
  parameter int LAT = 6,
  parameter int PW  = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P*W-1:0] g_a1,
  input  logic [P*W-1:0] g_b1,
  input  logic [P*W-1:0] g_a2,
  input  logic [P-1:0]   g_en,
  input  logic [W-1:0]   k0,
  input  logic [W-1:0]   k1,
  input  logic           iss_vld,
  input  logic [PW-1:0]  iss_idx,
  output logic           o_valid,
  output logic           o_sel,
  output logic [P*W-1:0] o_d,
  output logic [P-1:0]   o_en
);
  localparam logic [PW-1:0] LAST_SUB = PW'(P - 1);

  logic [W-1:0]  e_d1, e_d2;
  logic          e_en;

  // placeholder pipeline body: combine at entry, then delay LAT stages
  always_comb begin
    e_d1 = g_a1[iss_idx*W +: W] + g_b1[iss_idx*W +: W] + k0;
    e_d2 = g_a2[iss_idx*W +: W] - k1;
    e_en = g_en[iss_idx];
  end

  logic          st_vld [LAT];
  logic          st_en  [LAT];
  logic [PW-1:0] st_sub [LAT];
  logic [W-1:0]  st_d1  [LAT];
  logic [W-1:0]  st_d2  [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) st_vld[i] <= 1'b0;
    end else begin
      st_vld[0] <= iss_vld;
      for (int i = 1; i < LAT; i++) st_vld[i] <= st_vld[i-1];
    end
  end

  always_ff @(posedge clk) begin
    st_en[0]  <= e_en;
    st_sub[0] <= iss_idx;
    st_d1[0]  <= e_d1;
    st_d2[0]  <= e_d2;
    for (int i = 1; i < LAT; i++) begin
      st_en[i]  <= st_en[i-1];
      st_sub[i] <= st_sub[i-1];
      st_d1[i]  <= st_d1[i-1];
      st_d2[i]  <= st_d2[i-1];
    end
  end

  logic          t_vld, t_en;
  logic [PW-1:0] t_sub;
  logic [W-1:0]  t_d1, t_d2;
  assign t_vld = st_vld[LAT-1];
  assign t_en  = st_en[LAT-1];
  assign t_sub = st_sub[LAT-1];
  assign t_d1  = st_d1[LAT-1];
  assign t_d2  = st_d2[LAT-1];

  // collector: one entry per slot of the group
  logic [W-1:0] col_d1 [P];
  logic [W-1:0] col_d2 [P];
  logic         col_en [P];

  always_ff @(posedge clk) begin
    if (t_vld) begin
      col_d1[t_sub] <= t_d1;
      col_d2[t_sub] <= t_d2;
      col_en[t_sub] <= t_en;
    end
  end

  logic [P*W-1:0] m_d1, m_d2;
  logic [P-1:0]   m_en;
  logic           group_done;

  always_comb begin
    for (int s = 0; s < P; s++) begin
      if (s == P - 1) begin
        m_en[s]        = t_en;
        m_d1[s*W +: W] = t_en ? t_d1 : '0;
        m_d2[s*W +: W] = t_en ? t_d2 : '0;
      end else begin
        m_en[s]        = col_en[s];
        m_d1[s*W +: W] = col_en[s] ? col_d1[s] : '0;
        m_d2[s*W +: W] = col_en[s] ? col_d2[s] : '0;
      end
    end
    group_done = t_vld && (t_sub == LAST_SUB);
  end

  logic           pend;
  logic [P*W-1:0] pend_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_sel   <= 1'b0;
      o_en    <= '0;
      pend    <= 1'b0;
    end else if (group_done) begin
      o_valid <= 1'b1;
      o_sel   <= 1'b0;
      o_en    <= m_en;
      pend    <= 1'b1;
    end else if (pend) begin
      o_valid <= 1'b1;
      o_sel   <= 1'b1;
      pend    <= 1'b0;
    end else begin
      o_valid <= 1'b0;
      o_sel   <= 1'b0;
      o_en    <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (group_done) begin
      o_d     <= m_d1;
      pend_d2 <= m_d2;
    end else if (pend) begin
      o_d     <= pend_d2;
    end
  end

  // R10: a D1 wave is always followed by its D2 wave
  a_r10_d2_follows: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_sel) |=> (o_valid && o_sel));

  // R10: a D2 wave is only presented right after a D1 wave
  a_r10_d1_precedes: assert property (@(posedge clk) disable iff (rst)
    (o_valid && o_sel) |-> $past(o_valid && !o_sel));

  // R6: enables never appear outside a wave
  a_r6_en_in_wave: assert property (@(posedge clk) disable iff (rst)
    (|o_en) |-> o_valid);

  // R4: slots leave the pipeline in issue order
  a_r4_slot_order: assert property (@(posedge clk) disable iff (rst)
    (t_vld && (t_sub != LAST_SUB)) |=> (t_vld && (t_sub == PW'($past(t_sub) + 1'b1))));
endmodule

// File: rtl/wave_funnel.sv
module wave_funnel
  import funnel_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 32,
  parameter int LAT   = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_start,
  input  logic                   in_valid,
  input  logic [LANES-1:0]       in_en,
  input  logic [LANES*W-1:0]     in_a,
  input  logic [LANES*W-1:0]     in_b,
  output logic                   out_valid,
  output logic                   out_sel,
  output logic [LANES*W/8-1:0]   out_be,
  output logic [LANES*W-1:0]     out_d
);
  localparam int P     = PERIOD;
  localparam int PW    = idx_bits(P);
  localparam int NPIPE = LANES / P;   // LANES must be a multiple of P
  localparam int BE    = W / 8;

  logic [LANES*W-1:0] set_a1, set_b1, set_a2;
  logic [LANES-1:0]   set_en;
  logic [W-1:0]       set_k0, set_k1;
  logic               iss_vld;
  logic [PW-1:0]      iss_idx;

  funnel_seq #(.LANES(LANES), .W(W), .P(P), .PW(PW)) seq_i (
    .clk(clk), .rst(rst), .start(in_start), .valid(in_valid),
    .en(in_en), .a(in_a), .b(in_b),
    .set_a1(set_a1), .set_b1(set_b1), .set_a2(set_a2), .set_en(set_en),
    .set_k0(set_k0), .set_k1(set_k1), .iss_vld(iss_vld), .iss_idx(iss_idx)
  );

  logic [NPIPE-1:0] pv, ps;
  logic [LANES-1:0] pen;

  for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
    funnel_pipe #(.W(W), .P(P), .LAT(LAT), .PW(PW)) pipe_i (
      .clk(clk), .rst(rst),
      .g_a1(set_a1[g*P*W +: P*W]), .g_b1(set_b1[g*P*W +: P*W]),
      .g_a2(set_a2[g*P*W +: P*W]), .g_en(set_en[g*P +: P]),
      .k0(set_k0), .k1(set_k1), .iss_vld(iss_vld), .iss_idx(iss_idx),
      .o_valid(pv[g]), .o_sel(ps[g]),
      .o_d(out_d[g*P*W +: P*W]), .o_en(pen[g*P +: P])
    );

    if (g > 0) begin : g_lock
      // R5: every pipeline presents its lanes in the same wave
      a_r5_pipes_lockstep: assert property (@(posedge clk) disable iff (rst)
        (pv[g] == pv[0]) && (ps[g] == ps[0]));
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign out_be[l*BE +: BE] = {BE{pen[l]}};
  end

  assign out_valid = pv[0];
  assign out_sel   = ps[0];
endmodule

// File: tb/wave_funnel_tb.sv
module wave_funnel_tb_top;
  localparam int LANES = 4;
  localparam int W     = 32;
  localparam int LAT   = 6;
  localparam int BE    = W / 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_start = 1'b0;
  logic                 in_valid = 1'b0;
  logic [LANES-1:0]     in_en = '0;
  logic [LANES*W-1:0]   in_a = '0;
  logic [LANES*W-1:0]   in_b = '0;
  logic                 out_valid, out_sel;
  logic [LANES*BE-1:0]  out_be;
  logic [LANES*W-1:0]   out_d;

  wave_funnel #(.LANES(LANES), .W(W), .LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .in_start(in_start), .in_valid(in_valid),
    .in_en(in_en), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_sel(out_sel), .out_be(out_be), .out_d(out_d)
  );

  always #5 clk = ~clk;

  int edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  int    checks = 0;
  int    fails  = 0;
  bit    chk_on = 1'b0;
  bit    done   = 1'b0;
  string scen   = "R1 reset";

  // bench model state
  bit                 m_exec = 1'b1;
  int                 m_ph = 0;
  logic [W-1:0]       mk0 = '0, mk1 = '0;
  logic [LANES*W-1:0] ha, hb;
  logic [LANES-1:0]   hen;

  logic [LANES*W-1:0]  exp_d  [int];
  logic [LANES*BE-1:0] exp_be [int];
  bit                  exp_sel[int];

  function automatic logic [W-1:0] ref_d1(logic [W-1:0] a1, logic [W-1:0] b1, logic [W-1:0] k);
    return a1 + b1 + k;
  endfunction

  function automatic logic [W-1:0] ref_d2(logic [W-1:0] a2, logic [W-1:0] k);
    return a2 - k;
  endfunction

  function automatic logic [LANES*W-1:0] rnd_vec();
    logic [LANES*W-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*W +: W] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%s expected=%s at edge %0d", req, scen, act, expv, edge_n);
    end
  endtask

  // schedule the two output waves of a set completed by the beat under the coming edge
  task automatic schedule(input logic [LANES-1:0] e2, input logic [LANES*W-1:0] a2);
    logic [LANES*W-1:0]  w1, w2;
    logic [LANES*BE-1:0] be;
    int key;
    for (int l = 0; l < LANES; l++) begin
      bit on;
      on = hen[l] & e2[l];
      w1[l*W +: W]   = on ? ref_d1(ha[l*W +: W], hb[l*W +: W], mk0) : '0;
      w2[l*W +: W]   = on ? ref_d2(a2[l*W +: W], mk1) : '0;
      be[l*BE +: BE] = {BE{on}};
    end
    key = edge_n + LAT + 3;
    exp_d[key] = w1; exp_be[key] = be; exp_sel[key] = 1'b0;
    exp_d[key+1] = w2; exp_be[key+1] = be; exp_sel[key+1] = 1'b1;
  endtask

  task automatic beat(input bit st, input bit v, input logic [LANES-1:0] e,
                      input logic [LANES*W-1:0] a, input logic [LANES*W-1:0] b);
    @(negedge clk);
    if (st) begin
      m_exec = !m_exec;
      m_ph = 0;
    end
    if (v) begin
      if (!m_exec) begin
        mk0 = a[W-1:0];
        mk1 = b[W-1:0];
      end else if (m_ph == 0) begin
        ha = a; hb = b; hen = e;
        m_ph = 1;
      end else begin
        schedule(e, a);
        m_ph = 0;
      end
    end
    in_start = st; in_valid = v; in_en = e; in_a = a; in_b = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(1'b0, 1'b0, '0, rnd_vec(), rnd_vec());
  endtask

  task automatic load_k(input logic [W-1:0] k0, input logic [W-1:0] k1);
    logic [LANES*W-1:0] a, b;
    a = rnd_vec(); b = rnd_vec();
    a[W-1:0] = k0; b[W-1:0] = k1;
    beat(1'b1, 1'b1, '1, a, b);
  endtask

  // output checker
  always @(negedge clk) begin
    if (chk_on) begin
      if (exp_sel.exists(edge_n)) begin
        check(out_valid && (out_sel == exp_sel[edge_n]), "R4/R10",
              $sformatf("valid=%0b sel=%0b", out_valid, out_sel),
              $sformatf("valid=1 sel=%0b", exp_sel[edge_n]));
        check(out_be == exp_be[edge_n], "R6",
              $sformatf("%h", out_be), $sformatf("%h", exp_be[edge_n]));
        check(out_d == exp_d[edge_n], "R3/R5",
              $sformatf("%h", out_d), $sformatf("%h", exp_d[edge_n]));
        exp_sel.delete(edge_n); exp_be.delete(edge_n); exp_d.delete(edge_n);
      end else begin
        // R7: load beats and idle cycles present no wave
        check(!out_valid && (out_be == '0), "R4/R7",
              $sformatf("valid=%0b be=%h", out_valid, out_be), "valid=0 be=0");
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!out_valid && (out_be == '0), "R1",
          $sformatf("valid=%0b be=%h", out_valid, out_be), "valid=0 be=0");
    rst = 1'b0;
    chk_on = 1'b1;
    idle(3);

    // R7: first start is a load; a second load beat overwrites the scalars
    scen = "R7 multi-beat load";
    load_k(32'd5, 32'd3);
    beat(1'b0, 1'b1, '1, rnd_vec(), rnd_vec());
    idle(2);

    // R9 R3 R5: four sets back to back
    scen = "R9 back-to-back";
    beat(1'b1, 1'b1, '1, rnd_vec(), rnd_vec());
    for (int i = 0; i < 7; i++) beat(1'b0, 1'b1, '1, rnd_vec(), rnd_vec());
    idle(LAT + 6);

    // R2: stall between the phases, phase-1 B ignored
    scen = "R2 stalled phases";
    load_k(32'hFFFF_FFFF, 32'h0000_0010);
    beat(1'b1, 1'b1, '1, rnd_vec(), rnd_vec());
    idle(3);
    beat(1'b0, 1'b1, '1, rnd_vec(), rnd_vec());
    idle(LAT + 6);

    // R6: lane enables that differ between the two beats
    scen = "R6 partial enables";
    load_k(32'd100, 32'd7);
    beat(1'b1, 1'b1, 4'b0101, rnd_vec(), rnd_vec());
    beat(1'b0, 1'b1, 4'b0111, rnd_vec(), rnd_vec());
    beat(1'b0, 1'b1, 4'b1110, rnd_vec(), rnd_vec());
    beat(1'b0, 1'b1, 4'b1011, rnd_vec(), rnd_vec());
    idle(LAT + 6);

    // R8: reload while results are in flight
    scen = "R8 reload in flight";
    load_k(32'd1, 32'd2);
    beat(1'b1, 1'b1, '1, rnd_vec(), rnd_vec());
    beat(1'b0, 1'b1, '1, rnd_vec(), rnd_vec());
    load_k(32'h1234_0000, 32'h0000_4321);
    beat(1'b1, 1'b1, '1, rnd_vec(), rnd_vec());
    beat(1'b0, 1'b1, '1, rnd_vec(), rnd_vec());
    idle(LAT + 6);

    // random mix including starts in the middle of a set
    scen = "R3 R5 R6 random";
    for (int i = 0; i < 400; i++) begin
      bit st, v;
      logic [LANES-1:0] e;
      st = (($urandom % 8) == 0);
      v  = (($urandom % 5) != 0);
      e  = (($urandom % 10) < 7) ? '1 : LANES'($urandom);
      beat(st, v, e, rnd_vec(), rnd_vec());
    end
    idle(LAT + 8);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule